// File: doc/BRIEF.md
# Command-Sequence Write Lock

This block decides, one captured write at a time, whether a byte may pass on to the page buffer. It watches the stream of address/data pairs produced by the write-capture logic and recognises two fixed command sequences. A three-write arming sequence turns on a software lock. The same sequence also acts as a one-shot key that opens a single page-load window while the lock is on. A six-write sequence removes the lock. A hardware-inhibit input vetoes every write, whatever the lock state.

The lock bit stands in for a non-volatile cell, so the block reset does not clear it. Only its power-up initial value is unprotected. The block reset does close any open load window and does return the sequence matcher to idle. The page-load timer runs outside this block and reports through a single-cycle expiry pulse. That pulse aborts a partial command sequence and closes the load window.

The allow output is combinational from the strobe, so the page buffer gets its answer in the same cycle as the write. The lock flag and the window are registered and change in the cycle after the write that moves them.

Top module: `wrlock_gate`

## Requirements
- R1: Out of the first reset after power-up, lock_o is 0 and every write strobe with hw_inhibit low is allowed.
- R2: Three accepted writes in a row arm the lock: data 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. lock_o is 1 from the cycle after the third write. While unlocked, these three writes are themselves allowed.
- R3: An arming sequence opens a load window. Every write inside the window is allowed as data. After a win_expired pulse, writes are blocked again while the lock is on.
- R4: While locked with no open window, every write is blocked, including command writes. Issuing the arming sequence again reopens the window, and lock_o stays 1.
- R5: Six accepted writes in a row clear the lock: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. lock_o is 0 from the cycle after the sixth write, and later writes are allowed.
- R6: A write whose address or data does not match the expected step returns the matcher to idle. That write is not re-evaluated as a first step.
- R7: A win_expired pulse in the middle of a sequence returns the matcher to idle, so the rest of the sequence has no effect.
- R8: While hw_inhibit is 1, allow_o is 0. A strobe in that state neither advances nor aborts the matcher.
- R9: rst_n leaves lock_o unchanged. It closes the load window and returns the matcher to idle.
- R10: allow_o can be 1 only in a cycle in which wr_stb is 1.
- R11: While the load window is open, writes are treated as data and are not matched. A full clearing sequence issued inside the window leaves lock_o at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; does not clear the lock |
| wr_stb | input | 1 | One-cycle strobe per captured write |
| wr_addr | input | 15 | Captured write address |
| wr_data | input | 8 | Captured write data |
| win_expired | input | 1 | One-cycle pulse when the page-load timer runs out |
| hw_inhibit | input | 1 | Hardware write veto (bad enable levels or power-up delay) |
| lock_o | output | 1 | Software lock state |
| allow_o | output | 1 | The current write may enter the page buffer |

## Verification
The hardest states to reach from the ports are those that combine a lock state with a partly matched sequence. Examples are an inhibited strobe or a timer expiry landing between command writes, a clearing sequence sent while a one-shot window is still open, and a reset arriving while the lock is set. The stimulus reaches each of these by walking one ordered vector table through arm, expire, re-key, disarm, abort and inhibit phases, with the lock state carried over from row to row. Directed tests then apply reset in the middle of a sequence with the lock on. The bench checks that the lock survives the reset, that the window has closed, and that the pending sequence has been forgotten.

// File: rtl/wrlock_pkg.sv
package wrlock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_G1   = 3'd1,
    ST_G2   = 3'd2,
    ST_D3   = 3'd3,
    ST_D4   = 3'd4,
    ST_D5   = 3'd5
  } step_e;

  typedef struct packed {
    logic hit;     // write matched the expected step
    logic arm;     // arming sequence completed
    logic disarm;  // clearing sequence completed
    logic abort;   // mismatch while a sequence was pending
  } evt_t;

  function automatic logic pair_eq(input logic [31:0] addr, input logic [31:0] key_addr,
                                   input logic [15:0] data, input logic [15:0] key_data);
    return (addr == key_addr) && (data == key_data);
  endfunction

endpackage

// File: rtl/wrlock_match.sv
module wrlock_match
  import wrlock_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_A = 15'h5555,
  parameter logic [ADDR_W-1:0] KEY_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] D_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0] D_SECOND = 8'h55,
  parameter logic [DATA_W-1:0] D_ARM    = 8'hA0,
  parameter logic [DATA_W-1:0] D_EXT    = 8'h80,
  parameter logic [DATA_W-1:0] D_OFF    = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              flush,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output evt_t              evt
);

  step_e step_q, step_nxt;
  logic  on_a, on_b;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] k,
                              input logic [DATA_W-1:0] d, input logic [DATA_W-1:0] kd);
    return pair_eq(32'(a), 32'(k), 16'(d), 16'(kd));
  endfunction

  assign on_a = (addr == KEY_A);
  assign on_b = (addr == KEY_B);

  always_comb begin
    step_nxt = ST_IDLE;
    evt      = '0;
    unique case (step_q)
      ST_IDLE: if (at(addr, KEY_A, data, D_FIRST))  begin evt.hit = 1'b1; step_nxt = ST_G1; end
      ST_G1:   if (at(addr, KEY_B, data, D_SECOND)) begin evt.hit = 1'b1; step_nxt = ST_G2; end
      ST_G2: begin
        if (on_a && data == D_ARM) begin
          evt.hit = 1'b1;
          evt.arm = en;
        end else if (on_a && data == D_EXT) begin
          evt.hit  = 1'b1;
          step_nxt = ST_D3;
        end
      end
      ST_D3:   if (at(addr, KEY_A, data, D_FIRST))  begin evt.hit = 1'b1; step_nxt = ST_D4; end
      ST_D4:   if (on_b && data == D_SECOND)        begin evt.hit = 1'b1; step_nxt = ST_D5; end
      ST_D5:   if (at(addr, KEY_A, data, D_OFF))    begin evt.hit = 1'b1; evt.disarm = en; end
      default: step_nxt = ST_IDLE;
    endcase
    evt.hit   = evt.hit & en;
    evt.abort = en & ~evt.hit & (step_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step_q <= ST_IDLE;
    else if (flush) step_q <= ST_IDLE;
    else if (en)    step_q <= step_nxt;
  end

endmodule

// File: rtl/wrlock_state.sv
module wrlock_state (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  input  logic expire,
  output logic lock_q,
  output logic win_q
);

  logic lock_r = 1'b0;  // power-up value only; stands in for a non-volatile cell

  always_ff @(posedge clk) begin
    if (arm)         lock_r <= 1'b1;
    else if (disarm) lock_r <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= 1'b0;
    else if (arm)    win_q <= 1'b1;
    else if (expire || disarm) win_q <= 1'b0;
  end

  assign lock_q = lock_r;

endmodule

// File: rtl/wrlock_gate.sv
module wrlock_gate
  import wrlock_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              win_expired,
  input  logic              hw_inhibit,
  output logic              lock_o,
  output logic              allow_o
);

  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(15'h5555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'(15'h2AAA);

  logic wr_valid, match_en, match_flush, win_open;
  logic arm_evt, disarm_evt, seq_abort;
  evt_t evt;

  assign wr_valid    = wr_stb & ~hw_inhibit;
  assign match_en    = wr_valid & ~win_open;
  assign match_flush = win_expired | win_open;

  wrlock_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B),
    .D_FIRST(DATA_W'(8'hAA)), .D_SECOND(DATA_W'(8'h55)), .D_ARM(DATA_W'(8'hA0)),
    .D_EXT(DATA_W'(8'h80)), .D_OFF(DATA_W'(8'h20))
  ) u_match (
    .clk(clk), .rst_n(rst_n), .en(match_en), .flush(match_flush),
    .addr(wr_addr), .data(wr_data), .evt(evt)
  );

  assign arm_evt    = evt.arm;
  assign disarm_evt = evt.disarm;
  assign seq_abort  = evt.abort;

  wrlock_state u_state (
    .clk(clk), .rst_n(rst_n), .arm(arm_evt), .disarm(disarm_evt),
    .expire(win_expired), .lock_q(lock_o), .win_q(win_open)
  );

  assign allow_o = wr_valid & (~lock_o | win_open);

endmodule

// File: rtl/wrlock_chk.sv
module wrlock_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic hw_inhibit,
  input logic win_expired,
  input logic allow_o,
  input logic lock_o,
  input logic arm_evt,
  input logic disarm_evt,
  input logic seq_abort
);

  AST_ARM_LOCKS: assert property (@(posedge clk) disable iff (!rst_n) arm_evt |=> lock_o); // R2
  AST_DISARM_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n) disarm_evt |=> !lock_o); // R5
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!arm_evt && !disarm_evt) |=> $stable(lock_o)); // R4
  AST_EXPIRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) (win_expired && !arm_evt) |=> !(lock_o && wr_stb && allow_o)); // R3
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n) seq_abort |=> !(arm_evt || disarm_evt)); // R6
  AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) hw_inhibit |-> !allow_o); // R8
  AST_ALLOW_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n) allow_o |-> wr_stb); // R10

endmodule

bind wrlock_gate wrlock_chk u_chk (.*);

// File: tb/wrlock_gate_tb.sv
module wrlock_gate_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        win_expired = 1'b0;
  logic        hw_inhibit = 1'b0;
  logic        lock_o, allow_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  wrlock_gate u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_expired(win_expired), .hw_inhibit(hw_inhibit), .lock_o(lock_o), .allow_o(allow_o)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        stb;
    logic        inh;
    logic        exp;
    logic [14:0] addr;
    logic [7:0]  data;
    logic        allow;
    logic        lock;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t TBL [NV] = '{
    '{8'd2,  1,0,0,15'h5555,8'hAA,1,0},  // R2 arm step 1
    '{8'd2,  1,0,0,15'h2AAA,8'h55,1,0},
    '{8'd2,  1,0,0,15'h5555,8'hA0,1,1},  // R2 armed
    '{8'd3,  1,0,0,15'h0100,8'h12,1,1},  // R3 data inside window
    '{8'd3,  0,0,1,15'h0000,8'h00,0,1},  // R3 expiry
    '{8'd3,  1,0,0,15'h0100,8'h34,0,1},  // R3 blocked after expiry
    '{8'd4,  1,0,0,15'h5555,8'hAA,0,1},  // R4 command writes blocked
    '{8'd4,  1,0,0,15'h2AAA,8'h55,0,1},
    '{8'd4,  1,0,0,15'h5555,8'hA0,0,1},
    '{8'd4,  1,0,0,15'h0140,8'h56,1,1},  // R4 window reopened
    '{8'd3,  0,0,1,15'h0000,8'h00,0,1},
    '{8'd5,  1,0,0,15'h5555,8'hAA,0,1},  // R5 clearing sequence
    '{8'd5,  1,0,0,15'h2AAA,8'h55,0,1},
    '{8'd5,  1,0,0,15'h5555,8'h80,0,1},
    '{8'd5,  1,0,0,15'h5555,8'hAA,0,1},
    '{8'd5,  1,0,0,15'h2AAA,8'h55,0,1},
    '{8'd5,  1,0,0,15'h5555,8'h20,0,0},  // R5 cleared
    '{8'd5,  1,0,0,15'h0200,8'h78,1,0},
    '{8'd6,  1,0,0,15'h5555,8'hAA,1,0},  // R6 step 1
    '{8'd6,  1,0,0,15'h5555,8'hAA,1,0},  // R6 mismatch, not a new step 1
    '{8'd6,  1,0,0,15'h2AAA,8'h55,1,0},
    '{8'd6,  1,0,0,15'h5555,8'hA0,1,0},  // R6 no arm
    '{8'd8,  1,0,0,15'h5555,8'hAA,1,0},  // R8 step 1
    '{8'd8,  1,1,0,15'h0000,8'h00,0,0},  // R8 inhibited strobe blocked and ignored
    '{8'd8,  1,0,0,15'h2AAA,8'h55,1,0},
    '{8'd8,  1,0,0,15'h5555,8'hA0,1,1},  // R8 sequence survived
    '{8'd11, 1,0,0,15'h5555,8'hAA,1,1},  // R11 clearing sequence inside window
    '{8'd11, 1,0,0,15'h2AAA,8'h55,1,1},
    '{8'd11, 1,0,0,15'h5555,8'h80,1,1},
    '{8'd11, 1,0,0,15'h5555,8'hAA,1,1},
    '{8'd11, 1,0,0,15'h2AAA,8'h55,1,1},
    '{8'd11, 1,0,0,15'h5555,8'h20,1,1},  // R11 lock kept
    '{8'd10, 0,0,1,15'h0000,8'h00,0,1},  // R10 no strobe, no allow
    '{8'd7,  1,0,0,15'h5555,8'hAA,0,1},  // R7 step 1
    '{8'd7,  1,0,0,15'h2AAA,8'h55,0,1},
    '{8'd7,  0,0,1,15'h0000,8'h00,0,1},  // R7 expiry mid-sequence
    '{8'd7,  1,0,0,15'h5555,8'hA0,0,1},
    '{8'd7,  1,0,0,15'h0300,8'h9A,0,1}   // R7 window not reopened
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic stb, input logic inh, input logic ex,
                       input logic [14:0] a, input logic [7:0] d,
                       input logic exp_allow, input logic exp_lock, input string tag);
    @(negedge clk);
    wr_stb = stb; hw_inhibit = inh; win_expired = ex; wr_addr = a; wr_data = d;
    #1 check({tag, " allow"}, allow_o, exp_allow);
    @(posedge clk);
    #1 check({tag, " lock"}, lock_o, exp_lock);
    wr_stb = 1'b0; hw_inhibit = 1'b0; win_expired = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 lock after reset", lock_o, 1'b0);
    check("R1 idle allow", allow_o, 1'b0);
    drive(1,0,0,15'h0010,8'h01,1,0,"R1 plain write");

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].stb, TBL[i].inh, TBL[i].exp, TBL[i].addr, TBL[i].data,
            TBL[i].allow, TBL[i].lock, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // R9: re-arm, then reset with the window open
    drive(1,0,0,15'h5555,8'hAA,0,1,"R9 key1");
    drive(1,0,0,15'h2AAA,8'h55,0,1,"R9 key2");
    drive(1,0,0,15'h5555,8'hA0,0,1,"R9 key3");
    pulse_reset();
    #1 check("R9 lock survives reset", lock_o, 1'b1);
    drive(1,0,0,15'h0400,8'h11,0,1,"R9 window closed by reset");
    // R9: reset in the middle of a sequence
    drive(1,0,0,15'h5555,8'hAA,0,1,"R9 partial1");
    drive(1,0,0,15'h2AAA,8'h55,0,1,"R9 partial2");
    pulse_reset();
    drive(1,0,0,15'h5555,8'hA0,0,1,"R9 stale step3");
    drive(1,0,0,15'h0400,8'h22,0,1,"R9 matcher idled");
    // R5: clear to finish
    drive(1,0,0,15'h5555,8'hAA,0,1,"R5 c1");
    drive(1,0,0,15'h2AAA,8'h55,0,1,"R5 c2");
    drive(1,0,0,15'h5555,8'h80,0,1,"R5 c3");
    drive(1,0,0,15'h5555,8'hAA,0,1,"R5 c4");
    drive(1,0,0,15'h2AAA,8'h55,0,1,"R5 c5");
    drive(1,0,0,15'h5555,8'h20,0,0,"R5 c6");
    drive(1,0,0,15'h0500,8'h33,1,0,"R5 open write");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule